// File: doc/BRIEF.md
# Background Flash Streaming Read Engine

This block copies a linear run of 32-bit words out of a flash read port into a small local FIFO, so that a DMA channel can drain it without taking part in flash traffic. Software first writes a word-aligned start address, then writes a nonzero word count. The engine then works in the background. It issues one read at a time, and only in cycles when the flash port reports that no other traffic is using it. Each returned word is pushed into a two-entry FIFO.

A consumer pops words by reading the FIFO data register through the same register port. The full and empty flags are brought out as pins. Writing a count of zero stops the stream at once. Every request carries an epoch bit that flips on each such stop. A response that comes back with a stale epoch is dropped, so a new stream can be set up right away.

Top module: `flash_stream_engine`

## Requirements
- R1: After reset the address and count registers read 0, a read of the FIFO data register returns 0, `fifo_empty` is 1 and `fifo_full` is 0.
- R2: Register select 0 is the start address; bits 1:0 of it always read 0 whatever was written, and every `fl_addr` has bits 1:0 equal to 0.
- R3: A stream fetches consecutive words: each request's `fl_addr` is 4 above the previous request's, starting at the programmed address, and the words reach the FIFO in request order.
- R4: Register select 1 is the 22-bit word count (upper bits read 0). A nonzero write starts streaming, each request lowers the count by one, and no request is made once it is 0, so a count of N yields exactly N requests.
- R5: `fl_req` is asserted only in cycles where `fl_idle` is 1.
- R6: At most one read is outstanding: after a request, no new request is made until its response is accepted or the stream is stopped.
- R7: The FIFO holds exactly 2 words; `fifo_full` is 1 at two words and `fifo_empty` is 1 at zero, never both.
- R8: No request is made while the stored words plus the outstanding read reach 2. The stream stalls while full and resumes after a pop.
- R9: Reading register select 2 returns the oldest word and removes it. When the FIFO is empty, such a read returns 0 and leaves the flags unchanged.
- R10: Writing 0 to the count halts the stream, and the data of a read already in flight never enters the FIFO. A new stream can be started straight afterwards.
- R11: `fl_tag` carries the current epoch bit, which toggles on every write of 0 to the count. A response is accepted only when `fl_rtag` equals the current epoch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops when select is 2) |
| reg_sel | input | 2 | Register select: 0 address, 1 count, 2 FIFO data, 3 reads 0 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the current select |
| fl_idle | input | 1 | Flash port free of other traffic this cycle |
| fl_req | output | 1 | Read request, taken in any cycle where it is high |
| fl_addr | output | 32 | Byte address of the requested word |
| fl_tag | output | 1 | Epoch bit sent with the request |
| fl_rvalid | input | 1 | Response valid |
| fl_rdata | input | 32 | Response word |
| fl_rtag | input | 1 | Epoch bit returned with the response |
| fifo_full | output | 1 | FIFO holds 2 words |
| fifo_empty | output | 1 | FIFO holds no word |

## Verification
The checker watches every cycle for the rules that concern a single request: a request only while the port is idle, no second request straight after one, no request while the FIFO is full, a 4-byte address step, a count step of one per request, and full and empty never set together. The bench scenarios show what only a sequence can show. These are the exact number of requests for a given count, the data order after a stall, reads of an empty FIFO, and an abort whose late response is kept out of the FIFO before a fresh stream starts.

// File: rtl/fstrm_pkg.sv
package fstrm_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_DATA  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/fstrm_rst_sync.sv
module fstrm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/fstrm_fifo.sv
module fstrm_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [W-1:0]     ent_data [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [W-1:0] data_q;
    logic         ent_en;
    assign ent_en = push && (wr_ptr_q == PTR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      data_q <= '0;
      else if (ent_en) data_q <= push_data;
    end
    assign ent_data[i] = data_q;
  end

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = push ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop  ? ptr_inc(rd_ptr_q) : rd_ptr_q;
    lvl_d    = lvl_q;
    if (push && !pop)      lvl_d = lvl_q + 1'b1;
    else if (pop && !push) lvl_d = lvl_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      lvl_q    <= '0;
    end else if (push || pop) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      lvl_q    <= lvl_d;
    end
  end

  assign head  = ent_data[rd_ptr_q];
  assign level = lvl_q;
  assign full  = (lvl_q == LVL_W'(DEPTH));
  assign empty = (lvl_q == '0);
endmodule

// File: rtl/fstrm_ctrl.sv
module fstrm_ctrl #(
  parameter int REG_W = 32,
  parameter int CNT_W = 22,
  parameter int DEPTH = 2,
  localparam int WA_W  = REG_W - 2,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_addr_en,
  input  logic             wr_cnt_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             fl_idle,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             rsp_valid,
  input  logic             rsp_tag,
  output logic             issue,
  output logic             accept,
  output logic             epoch,
  output logic [WA_W-1:0]  word_addr,
  output logic [CNT_W-1:0] count
);
  logic [WA_W-1:0]  waddr_q, waddr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             epoch_q, epoch_d;
  logic             infl_q, infl_d;
  logic             abort, room, reg_busy, en_waddr, en_cnt, en_infl;

  always_comb begin
    abort    = wr_cnt_en && (wdata[CNT_W-1:0] == '0);
    reg_busy = wr_addr_en || wr_cnt_en;
    room     = (fifo_level + LVL_W'(infl_q)) < LVL_W'(DEPTH);
    issue    = (cnt_q != '0) && !infl_q && fl_idle && room && !reg_busy;
    accept   = rsp_valid && infl_q && (rsp_tag == epoch_q) && !abort;

    en_waddr = wr_addr_en || issue;
    waddr_d  = wr_addr_en ? wdata[REG_W-1:2] : waddr_q + 1'b1;

    en_cnt   = wr_cnt_en || issue;
    cnt_d    = wr_cnt_en ? wdata[CNT_W-1:0] : cnt_q - 1'b1;

    epoch_d  = ~epoch_q;

    en_infl  = abort || issue || accept;
    infl_d   = issue && !abort;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waddr_q <= '0;
      cnt_q   <= '0;
      epoch_q <= 1'b0;
      infl_q  <= 1'b0;
    end else begin
      if (en_waddr) waddr_q <= waddr_d;
      if (en_cnt)   cnt_q   <= cnt_d;
      if (abort)    epoch_q <= epoch_d;
      if (en_infl)  infl_q  <= infl_d;
    end
  end

  assign epoch     = epoch_q;
  assign word_addr = waddr_q;
  assign count     = cnt_q;
endmodule

// File: rtl/flash_stream_engine.sv
module flash_stream_engine #(
  parameter int REG_W      = 32,
  parameter int CNT_W      = 22,
  parameter int FIFO_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             fl_idle,
  output logic             fl_req,
  output logic [REG_W-1:0] fl_addr,
  output logic             fl_tag,
  input  logic             fl_rvalid,
  input  logic [REG_W-1:0] fl_rdata,
  input  logic             fl_rtag,
  output logic             fifo_full,
  output logic             fifo_empty
);
  import fstrm_pkg::*;

  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  logic             rst_sync_n;
  reg_sel_e         sel;
  logic             wr_addr_en, wr_cnt_en, pop, push;
  logic [LVL_W-1:0] fifo_level;
  logic [REG_W-1:0] fifo_head;
  logic [REG_W-3:0] word_addr;
  logic [CNT_W-1:0] cnt_w;

  fstrm_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_sync_n)
  );

  assign sel        = reg_sel_e'(reg_sel);
  assign wr_addr_en = reg_wr && (sel == SEL_ADDR);
  assign wr_cnt_en  = reg_wr && (sel == SEL_COUNT);
  assign pop        = reg_rd && (sel == SEL_DATA) && !fifo_empty;

  fstrm_ctrl #(.REG_W(REG_W), .CNT_W(CNT_W), .DEPTH(FIFO_DEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_addr_en(wr_addr_en), .wr_cnt_en(wr_cnt_en), .wdata(reg_wdata),
    .fl_idle(fl_idle), .fifo_level(fifo_level),
    .rsp_valid(fl_rvalid), .rsp_tag(fl_rtag),
    .issue(fl_req), .accept(push), .epoch(fl_tag),
    .word_addr(word_addr), .count(cnt_w)
  );

  fstrm_fifo #(.W(REG_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_sync_n),
    .push(push), .push_data(fl_rdata), .pop(pop),
    .head(fifo_head), .level(fifo_level),
    .full(fifo_full), .empty(fifo_empty)
  );

  assign fl_addr = {word_addr, 2'b00};

  always_comb begin
    unique case (sel)
      SEL_ADDR:  reg_rdata = {word_addr, 2'b00};
      SEL_COUNT: reg_rdata = {{(REG_W-CNT_W){1'b0}}, cnt_w};
      SEL_DATA:  reg_rdata = fifo_empty ? '0 : fifo_head;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fstrm_chk.sv
module fstrm_chk #(
  parameter int REG_W = 32,
  parameter int CNT_W = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fl_req,
  input logic             fl_idle,
  input logic [REG_W-1:0] fl_addr,
  input logic             fifo_full,
  input logic             fifo_empty,
  input logic [CNT_W-1:0] cnt
);
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req |=> fl_addr == $past(fl_addr) + REG_W'(4));

  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req |=> cnt == $past(cnt) - 1'b1);

  a_r5_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req |-> fl_idle);

  a_r6_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req |=> !fl_req);

  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fl_req);
endmodule

bind flash_stream_engine fstrm_chk #(.REG_W(REG_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .fl_req(fl_req), .fl_idle(fl_idle),
  .fl_addr(fl_addr), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
  .cnt(cnt_w)
);

// File: tb/flash_stream_engine_tb_top.sv
`timescale 1ns/1ps
module flash_stream_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_sel = 2'd3;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fl_idle = 1'b1;
  logic        fl_req;
  logic [31:0] fl_addr;
  logic        fl_tag;
  logic        fl_rvalid = 1'b0;
  logic [31:0] fl_rdata = '0;
  logic        fl_rtag = 1'b0;
  logic        fifo_full, fifo_empty;

  int n_checks = 0, n_fail = 0, n_req = 0, lat = 2;
  int pend_cnt = 0;
  logic [31:0] pend_addr = '0;
  logic        pend_tag = 1'b0;
  logic        addr_bad = 1'b0;

  always #4 clk = ~clk;

  flash_stream_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fl_idle(fl_idle), .fl_req(fl_req), .fl_addr(fl_addr), .fl_tag(fl_tag),
    .fl_rvalid(fl_rvalid), .fl_rdata(fl_rdata), .fl_rtag(fl_rtag),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty)
  );

  function automatic logic [31:0] word_of(input logic [31:0] a);
    return a ^ 32'h5A3C_0000;
  endfunction

  // flash model: one pending read, fixed latency, one-cycle response pulse
  always @(negedge clk) begin
    #1;
    if (pend_cnt != 0) begin
      pend_cnt = pend_cnt - 1;
      if (pend_cnt == 0) begin
        fl_rvalid = 1'b1;
        fl_rdata  = word_of(pend_addr);
        fl_rtag   = pend_tag;
      end else fl_rvalid = 1'b0;
    end else fl_rvalid = 1'b0;
    if (fl_req) begin
      n_req     = n_req + 1;
      pend_cnt  = lat;
      pend_addr = fl_addr;
      pend_tag  = fl_tag;
      if (fl_addr[1:0] != 2'b00) addr_bad = 1'b1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 2'd3;
  endtask

  task automatic reg_read(input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_rd = 1'b1;
    #2 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; reg_sel = 2'd3;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 empty", 32'(fifo_empty), 32'd1);
    check("R1 full", 32'(fifo_full), 32'd0);
    reg_read(2'd0, v); check("R1 addr", v, 32'd0);
    reg_read(2'd1, v); check("R1 count", v, 32'd0);
    reg_read(2'd2, v); check("R1 data", v, 32'd0);
  endtask

  task automatic t_addr_reg;
    logic [31:0] v;
    reg_write(2'd0, 32'h1234_567F);
    reg_read(2'd0, v); check("R2 low bits read 0", v, 32'h1234_567C);
  endtask

  task automatic t_count_width;
    logic [31:0] v;
    fl_idle = 1'b0;
    reg_write(2'd1, 32'hFFFF_FFFF);
    reg_read(2'd1, v); check("R4 count width", v, 32'h003F_FFFF);
    reg_write(2'd1, 32'd0);
    reg_read(2'd1, v); check("R4 count cleared", v, 32'd0);
    fl_idle = 1'b1;
    wait_cycles(2);
    check("R5 no req while busy", 32'(n_req), 32'd0);
  endtask

  task automatic t_stream_stall;
    logic [31:0] v;
    int base;
    base = n_req; lat = 2;
    reg_write(2'd0, 32'h0000_0100);
    reg_write(2'd1, 32'd3);
    wait_cycles(20);
    check("R7 full at two", 32'(fifo_full), 32'd1);
    check("R8 stalled while full", 32'(n_req - base), 32'd2);
    reg_read(2'd2, v); check("R3 first word", v, word_of(32'h100));
    wait_cycles(10);
    reg_read(2'd2, v); check("R3 second word", v, word_of(32'h104));
    reg_read(2'd2, v); check("R8 resumed word", v, word_of(32'h108));
    check("R7 empty after drain", 32'(fifo_empty), 32'd1);
    check("R4 exactly N requests", 32'(n_req - base), 32'd3);
    reg_read(2'd1, v); check("R4 count at zero", v, 32'd0);
    reg_read(2'd0, v); check("R3 address advanced", v, 32'h0000_010C);
    wait_cycles(5);
    check("R4 no more requests", 32'(n_req - base), 32'd3);
  endtask

  task automatic t_idle_gate;
    logic [31:0] v;
    int base;
    base = n_req; lat = 3;
    fl_idle = 1'b0;
    reg_write(2'd0, 32'h0000_0200);
    reg_write(2'd1, 32'd2);
    wait_cycles(20);
    check("R5 held while not idle", 32'(n_req - base), 32'd0);
    fl_idle = 1'b1;
    wait_cycles(15);
    check("R5 issued when idle", 32'(n_req - base), 32'd2);
    reg_read(2'd2, v); check("R3 idle word 0", v, word_of(32'h200));
    reg_read(2'd2, v); check("R3 idle word 1", v, word_of(32'h204));
  endtask

  task automatic t_empty_read;
    logic [31:0] v;
    reg_read(2'd2, v); check("R9 empty read zero", v, 32'd0);
    check("R9 still empty", 32'(fifo_empty), 32'd1);
    check("R9 not full", 32'(fifo_full), 32'd0);
  endtask

  task automatic t_abort;
    logic [31:0] v;
    int base;
    base = n_req; lat = 10;
    reg_write(2'd0, 32'h0000_0400);
    reg_write(2'd1, 32'd5);
    wait_cycles(3);
    reg_write(2'd1, 32'd0);
    wait_cycles(20);
    check("R10 one request before abort", 32'(n_req - base), 32'd1);
    check("R11 stale response dropped", 32'(fifo_empty), 32'd1);
    reg_read(2'd1, v); check("R10 count halted", v, 32'd0);
    lat = 2;
    reg_write(2'd0, 32'h0000_0800);
    reg_write(2'd1, 32'd1);
    wait_cycles(10);
    reg_read(2'd2, v); check("R10 restart word", v, word_of(32'h800));
    check("R11 restart request count", 32'(n_req - base), 32'd2);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    wait_cycles(4);
    rst_n = 1'b1;
    wait_cycles(5);
    t_reset();
    t_addr_reg();
    t_count_width();
    t_stream_stall();
    t_idle_gate();
    t_empty_read();
    t_abort();
    check("R2 request addresses aligned", 32'(addr_bad), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule